// File: doc/BRIEF.md
# External memory bus cycle generator

This block turns single memory requests from an 8-bit processor core into read and write cycles on a non-multiplexed external bus. The bus has a 16-bit address, an 8-bit data path (split here into an output, an enable and an input, because the pad drivers live outside the block), active-low read and write strobes, and an active-low wait input that slow devices use to stretch a cycle. The block runs from a clock at twice the oscillator rate. One clock period, called a tick here, is half an oscillator period. A basic bus cycle is 8 ticks long, and a bus clock at one quarter of the oscillator rate is driven out alongside it.

Each request is first decoded. The low program region (0000h to 3FFFh, only while `rom_en` is high) and the on-chip RAM and I/O window (FDC0h to FFEFh) are served inside the chip. They finish at once with an internal-select pulse and no bus activity. Every other address runs one external cycle. The address is launched at the start of a bus cycle and the strobe falls two ticks later. The strobe stays low for five ticks, plus eight ticks for each bus-clock falling edge at which wait is seen low. Read data is captured as the strobe rises, and a done pulse follows one tick later.

Top module: `mbus_cycle_gen`

## Requirements
- R1: `bus_clk` has a period of 8 ticks, high for 4 and low for 4, and is high while reset is held.
- R2: `bus_addr` is unchanged for at least 2 ticks before a strobe falls. A strobe falls only while `bus_clk` is high. The address does not change while the strobe is low, nor in the tick in which it rises.
- R3: With `bus_wait_n` high, a strobe stays low for exactly 5 ticks and rises while `bus_clk` is low. `bus_rd_n` and `bus_wr_n` are never low together.
- R4: Between the rise of one strobe and the fall of the next, both strobes stay high for at least 3 ticks.
- R5: In a write cycle, `bus_data_oe` is high and `bus_data_o` equals the request's write data for at least 4 ticks before `bus_wr_n` rises, and for the whole time it is low.
- R6: `bus_wait_n` is sampled at each falling edge of `bus_clk` that occurs while a strobe is low. Every sample taken low adds 8 ticks to the strobe.
- R7: An address is internal if it lies in 0000h–3FFFh while `rom_en` = 1, or in FDC0h–FFEFh. An internal access raises `done` and `int_sel` together in the tick after acceptance and moves no strobe. Every other address gives exactly one strobe with `int_sel` = 0.
- R8: For an external read, `rdata` holds the value on `bus_data_i` at the rise of `bus_rd_n` while `done` is high. `bus_data_oe` is high only during write cycles.
- R9: `ack` is high in the same tick as `req` when the block is idle. `done` is a single-tick pulse, and for an external access it comes one tick after the strobe rises.
- R10: During reset both strobes are high and `bus_data_oe`, `done`, `int_sel` and `ack` (with `req` low) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at twice the oscillator rate (one tick = half an oscillator period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_en | input | 1 | High when the low program region is served internally |
| req | input | 1 | Access request, held until `ack` |
| req_addr | input | 16 | Access address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | Request accepted at this clock edge |
| done | output | 1 | One-tick pulse at the end of an access |
| rdata | output | 8 | Captured read data, valid with `done` |
| int_sel | output | 1 | Pulses with `done` when the access was served internally |
| bus_clk | output | 1 | Bus clock at one quarter of the oscillator rate |
| bus_addr | output | 16 | External address bus |
| bus_data_o | output | 8 | Data to drive onto the external data bus |
| bus_data_oe | output | 1 | Output enable for the data bus drivers |
| bus_data_i | input | 8 | Data read from the external data bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_wait_n | input | 1 | Active-low wait request from slow devices |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, the program region at 0000h–3FFFh and the internal window at FDC0h–FFEFh. With these values the exact region edges can be reached as directed cases: 3FFFh/4000h with `rom_en` at both values, 0000h with the program region turned off, and FDBFh/FDC0h and FFEFh/FFF0h. Random addresses are biased toward the three regions. Random wait counts from zero to three bring the stretched strobe widths of 13, 21 and 29 ticks within reach, next to the plain 5-tick strobe, for both reads and writes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    // Ticks are half oscillator periods; a basic bus cycle is 8 ticks.
    localparam int unsigned PH_W = 3;
    localparam logic [PH_W-1:0] PH_ADDR_LAST = 3'd1; // last tick before strobe falls
    localparam logic [PH_W-1:0] PH_SAMPLE    = 3'd3; // wait sampled at the edge leaving this phase
    localparam logic [PH_W-1:0] PH_LOW_LAST  = 3'd6; // last low tick of an unstretched strobe
    localparam logic [PH_W-1:0] PH_CYC_END   = 3'd7; // final tick of a bus cycle

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_ADDR,
        ST_STRB,
        ST_END
    } seq_state_e;
endpackage

// File: rtl/mbus_phase.sv
module mbus_phase
    import mbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            bus_clk
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase   = st_q.ph;
    assign bus_clk = ~st_q.ph[PH_W-1];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned ROM_LO = 32'h0000,
    parameter int unsigned ROM_HI = 32'h3FFF,
    parameter int unsigned INT_LO = 32'hFDC0,
    parameter int unsigned INT_HI = 32'hFFEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output logic              internal
);
    localparam logic [ADDR_W-1:0] ROM_LO_A = ADDR_W'(ROM_LO);
    localparam logic [ADDR_W-1:0] ROM_HI_A = ADDR_W'(ROM_HI);
    localparam logic [ADDR_W-1:0] INT_LO_A = ADDR_W'(INT_LO);
    localparam logic [ADDR_W-1:0] INT_HI_A = ADDR_W'(INT_HI);

    logic in_rom;
    logic in_win;

    generate
        if (ROM_LO == 0) begin : g_rom_from_zero
            assign in_rom = (addr <= ROM_HI_A);
        end else begin : g_rom_window
            assign in_rom = (addr >= ROM_LO_A) && (addr <= ROM_HI_A);
        end
    endgenerate

    assign in_win   = (addr >= INT_LO_A) && (addr <= INT_HI_A);
    assign internal = (rom_en && in_rom) || in_win;
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_internal,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack,
    output logic              done,
    output logic              int_sel,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              rd_n,
    output logic              wr_n
);
    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pend_addr;
        logic              pend_wr;
        logic [DATA_W-1:0] pend_wdata;
        logic [ADDR_W-1:0] bus_addr;
        logic              wait_hit;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              int_sel;
    } seq_t;

    seq_t st_d, st_q;
    logic accept;

    assign accept = req && (st_q.state == ST_IDLE);

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.int_sel = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req) begin
                    if (req_internal) begin
                        st_d.done    = 1'b1;
                        st_d.int_sel = 1'b1;
                    end else begin
                        st_d.pend_addr  = req_addr;
                        st_d.pend_wr    = req_wr;
                        st_d.pend_wdata = req_wdata;
                        if (phase == PH_CYC_END) begin
                            st_d.state    = ST_ADDR;
                            st_d.bus_addr = req_addr;
                        end else begin
                            st_d.state = ST_SLOT;
                        end
                    end
                end
            end
            ST_SLOT: begin
                if (phase == PH_CYC_END) begin
                    st_d.state    = ST_ADDR;
                    st_d.bus_addr = st_q.pend_addr;
                end
            end
            ST_ADDR: begin
                st_d.wait_hit = 1'b0;
                if (phase == PH_ADDR_LAST) st_d.state = ST_STRB;
            end
            ST_STRB: begin
                if (phase == PH_SAMPLE) st_d.wait_hit = ~wait_n;
                if (phase == PH_LOW_LAST && !st_q.wait_hit) begin
                    st_d.state = ST_END;
                    if (!st_q.pend_wr) st_d.rdata = data_i;
                end
            end
            ST_END: begin
                st_d.state = ST_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack     = accept;
    assign done    = st_q.done;
    assign int_sel = st_q.int_sel;
    assign rdata   = st_q.rdata;
    assign addr    = st_q.bus_addr;
    assign data_o  = st_q.pend_wdata;
    assign data_oe = st_q.pend_wr && ((st_q.state == ST_ADDR) ||
                                      (st_q.state == ST_STRB) ||
                                      (st_q.state == ST_END));
    assign rd_n    = ~((st_q.state == ST_STRB) && !st_q.pend_wr);
    assign wr_n    = ~((st_q.state == ST_STRB) &&  st_q.pend_wr);
endmodule

// File: rtl/mbus_cycle_gen.sv
module mbus_cycle_gen
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROM_LO = 32'h0000,
    parameter int unsigned ROM_HI = 32'h3FFF,
    parameter int unsigned INT_LO = 32'hFDC0,
    parameter int unsigned INT_HI = 32'hFFEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rom_en,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              int_sel,
    output logic              bus_clk,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    input  logic              bus_wait_n
);
    logic [PH_W-1:0] phase;
    logic            is_internal;

    mbus_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .bus_clk (bus_clk)
    );

    mbus_decode #(
        .ADDR_W (ADDR_W),
        .ROM_LO (ROM_LO),
        .ROM_HI (ROM_HI),
        .INT_LO (INT_LO),
        .INT_HI (INT_HI)
    ) u_decode (
        .addr     (req_addr),
        .rom_en   (rom_en),
        .internal (is_internal)
    );

    mbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .req          (req),
        .req_addr     (req_addr),
        .req_wr       (req_wr),
        .req_wdata    (req_wdata),
        .req_internal (is_internal),
        .wait_n       (bus_wait_n),
        .data_i       (bus_data_i),
        .ack          (ack),
        .done         (done),
        .int_sel      (int_sel),
        .rdata        (rdata),
        .addr         (bus_addr),
        .data_o       (bus_data_o),
        .data_oe      (bus_data_oe),
        .rd_n         (bus_rd_n),
        .wr_n         (bus_wr_n)
    );
endmodule

// File: rtl/mbus_cycle_gen_chk.sv
module mbus_cycle_gen_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_clk,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_data_oe,
    input logic              int_sel,
    input logic              done
);
    p_fall_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> (bus_clk && $stable(bus_addr)));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |=> $stable(bus_addr));

    p_rise_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_clk);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    p_recovery_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |=> (bus_rd_n && bus_wr_n));

    p_wdata_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (bus_data_oe && $past(bus_data_oe)));

    p_internal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (done && bus_rd_n && bus_wr_n));

    p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> bus_rd_n);
endmodule

bind mbus_cycle_gen mbus_cycle_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clk     (bus_clk),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_addr    (bus_addr),
    .bus_data_oe (bus_data_oe),
    .int_sel     (int_sel),
    .done        (done)
);

// File: tb/mbus_cycle_gen_tb.sv
module mbus_cycle_gen_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, rom_en, req, req_wr, ack, done, int_sel, bus_clk;
    logic [15:0] req_addr, bus_addr;
    logic [7:0]  req_wdata, rdata, bus_data_o, bus_data_i;
    logic        bus_data_oe, bus_rd_n, bus_wr_n, bus_wait_n;

    mbus_cycle_gen u_dut (
        .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .req(req), .req_addr(req_addr),
        .req_wr(req_wr), .req_wdata(req_wdata), .ack(ack), .done(done), .rdata(rdata),
        .int_sel(int_sel), .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_data_o(bus_data_o),
        .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_wait_n(bus_wait_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bit is_int(input logic [15:0] a, input bit rom);
        return (rom && a <= 16'h3FFF) || (a >= 16'hFDC0 && a <= 16'hFFEF);
    endfunction

    // Current access as seen by the tick monitor
    bit          cur_wr;
    logic [7:0]  cur_wdata;
    int          cur_nwait;
    // Tick monitor state
    int   tick, bclk_since, addr_stable, low_cnt, hi_ticks, oe_run, samp;
    int   falls, rise_tick, done_tick;
    bit   bclk_seen, had_strobe, addr_moved, oe_bad, prev_strobe, prev_wr_low, prev_bclk;
    logic [15:0] prev_addr, strobe_addr;

    always @(negedge clk) begin
        if (rst_n) begin
            bit strobe;
            tick++;
            // R1 bus clock half period
            bclk_since++;
            if (bus_clk != prev_bclk) begin
                if (bclk_seen) chk(bclk_since == 4, "R1 bus clock half period", bclk_since, 4);
                bclk_seen  = 1;
                bclk_since = 0;
            end
            if (bus_addr == prev_addr) addr_stable++;
            else                       addr_stable = 0;
            strobe = !bus_rd_n || !bus_wr_n;
            if (strobe && !prev_strobe) begin
                chk(addr_stable >= 2, "R2 address setup ticks", addr_stable, 2);
                chk(bus_clk == 1'b1, "R2 strobe falls with bus clock high", int'(bus_clk), 1);
                if (had_strobe) chk(hi_ticks >= 3, "R4 recovery ticks", hi_ticks, 3);
                low_cnt     = 1;
                strobe_addr = bus_addr;
                addr_moved  = 0;
                had_strobe  = 1;
                falls++;
            end else if (strobe) begin
                low_cnt++;
                if (bus_addr != strobe_addr) addr_moved = 1;
            end else if (prev_strobe) begin
                if (cur_nwait == 0)
                    chk(low_cnt == 5, "R3 strobe low ticks", low_cnt, 5);
                else
                    chk(low_cnt == 5 + 8 * cur_nwait, "R6 stretched strobe ticks",
                        low_cnt, 5 + 8 * cur_nwait);
                chk(!addr_moved && bus_addr == strobe_addr, "R2 address hold",
                    int'(bus_addr), int'(strobe_addr));
                if (prev_wr_low) chk(oe_run >= 4, "R5 write data lead ticks", oe_run, 4);
                rise_tick = tick;
                hi_ticks  = 1;
            end else begin
                hi_ticks++;
            end
            // slow device: hold wait low for cur_nwait samples
            if (strobe && prev_bclk && !bus_clk) begin
                samp++;
                if (samp >= cur_nwait) bus_wait_n = 1'b1;
            end
            if (bus_data_oe && !cur_wr) oe_bad = 1;
            if (done) done_tick = tick;
            if (bus_data_oe && bus_data_o == cur_wdata) oe_run++;
            else                                          oe_run = 0;
            prev_strobe = strobe;
            prev_wr_low = !bus_wr_n;
            prev_bclk   = bus_clk;
            prev_addr   = bus_addr;
        end
    end

    task automatic access(input logic [15:0] a, input bit w, input logic [7:0] wd,
                          input int nw, input bit rom);
        bit intl;
        int guard;
        intl = is_int(a, rom);
        @(negedge clk);
        cur_wr      = w;
        cur_wdata   = wd;
        cur_nwait   = nw;
        rom_en      = rom;
        bus_data_i  = 8'($urandom);
        bus_wait_n  = (nw == 0);
        falls       = 0;
        oe_bad      = 0;
        samp        = 0;
        req         = 1'b1;
        req_addr    = a;
        req_wr      = w;
        req_wdata   = wd;
        #1;
        chk(ack == 1'b1, "R9 ack while idle", int'(ack), 1);
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        if (intl) begin
            chk(done && int_sel, "R7 internal done and select next tick",
                int'({done, int_sel}), 3);
            @(negedge clk);
            chk(done == 1'b0, "R9 done single tick", int'(done), 0);
            chk(falls == 0, "R7 internal access moves no strobe", falls, 0);
        end else begin
            guard = 0;
            while (!done && guard < 400) begin
                @(negedge clk);
                guard++;
            end
            chk(guard < 400, "R9 external access completes", guard, 0);
            chk(int_sel == 1'b0, "R7 external access has no internal select", int'(int_sel), 0);
            if (!w) chk(rdata == bus_data_i, "R8 read data captured", int'(rdata), int'(bus_data_i));
            @(negedge clk);
            chk(done == 1'b0, "R9 done single tick", int'(done), 0);
            chk(done_tick == rise_tick + 1, "R9 done one tick after strobe rise",
                done_tick - rise_tick, 1);
            chk(falls == 1, "R7 external access gives one strobe", falls, 1);
        end
        chk(!oe_bad, "R8 data bus driven only in writes", int'(oe_bad), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; rom_en = 1'b1; req = 1'b0; req_addr = '0; req_wr = 1'b0;
        req_wdata = '0; bus_data_i = '0; bus_wait_n = 1'b1;
        cur_wr = 0; cur_wdata = '0; cur_nwait = 0;
        prev_bclk = 1'b1; prev_strobe = 0; prev_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state, R1 bus clock high in reset
        chk(bus_rd_n && bus_wr_n, "R10 strobes high in reset", int'({bus_rd_n, bus_wr_n}), 3);
        chk(!bus_data_oe && !done && !int_sel && !ack, "R10 outputs low in reset",
            int'({bus_data_oe, done, int_sel, ack}), 0);
        chk(bus_clk == 1'b1, "R1 bus clock high in reset", int'(bus_clk), 1);
        prev_addr = bus_addr;
        rst_n = 1'b1;

        // directed corners
        access(16'h4000, 0, 8'h00, 0, 1);   // R3 plain read
        access(16'h4001, 1, 8'hA5, 0, 1);   // R5 plain write
        access(16'h8000, 0, 8'h00, 3, 1);   // R6 read, three waits
        access(16'h8001, 1, 8'h3C, 2, 1);   // R6 write, two waits
        access(16'h3FFF, 0, 8'h00, 0, 1);   // R7 program region internal
        access(16'h3FFF, 0, 8'h00, 1, 0);   // R7 program region external when off
        access(16'h0000, 1, 8'h5A, 0, 0);   // R7 bottom address external
        access(16'h0000, 1, 8'h5A, 0, 1);   // R7 bottom address internal
        access(16'hFDBF, 0, 8'h00, 0, 1);   // R7 below window
        access(16'hFDC0, 1, 8'h11, 0, 0);   // R7 window start
        access(16'hFFEF, 0, 8'h00, 0, 0);   // R7 window end
        access(16'hFFF0, 1, 8'hEE, 1, 1);   // R7 above window
        access(16'hFFFF, 0, 8'h00, 0, 1);

        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            logic [15:0] a;
            case ($urandom % 4)
                0:       a = 16'($urandom % 32'h4000);
                1:       a = 16'h4000 + 16'($urandom % 32'hBDC0);
                2:       a = 16'hFDC0 + 16'($urandom % 32'h30);
                default: a = 16'hFFF0 + 16'($urandom % 32'h10);
            endcase
            access(a, 1'($urandom), 8'($urandom), int'($urandom % 4), 1'($urandom));
        end

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule